// File: doc/BRIEF.md
# Transmit clock loss monitor

This block watches the line transmit clock against a free-running master clock of about 2.048 MHz. Both clocks are oversampled by a faster system clock. When the transmit clock stops toggling for too many master-clock periods, the block raises a live loss status and a sticky, maskable interrupt. It then decides whether the transmit line driver keeps driving or goes to high impedance.

The same block picks the clock that paces internally generated transmit patterns (all ones, all zeros, PRBS, automatic all ones, AIS). It also emits a one-cycle data sample strobe on the configured edge of the transmit clock. The driver is held in high impedance whenever the master clock is absent, and after reset until the first master-clock transition is observed.

Top module: `tclk_loss_mon`

## Requirements
- R1: `tclk_lost` goes to 1 once more than LOSS_LIMIT (default 70) master-clock rising edges pass with no transmit clock edge of either polarity. It stays 0 while 60 or fewer such edges have passed.
- R2: `tclk_lost` returns to 0 by itself within a few system cycles after transmit clock edges are seen again, with no software action.
- R3: While `tclk_lost` is 1, `drv_oe` is 0 unless `remote_lb` is 1 or a pattern is active whose reference is the master clock.
- R4: While `mclk_present` is 0, `drv_oe` is 0 whatever the other inputs are.
- R5: When `tx_all_ones`, `tx_all_zeros` or `tx_prbs` is active, `patt_clk_en` pulses on master-clock rising edges if `cfg_patt_mclk` is 1. It pulses on transmit-clock rising edges if `cfg_patt_mclk` is 0.
- R6: When `auto_all_ones` or `ais_en` is 1, the master clock is the pattern reference and `cfg_patt_mclk` has no effect. This holds both for `patt_clk_en` and for the R3 driver decision.
- R7: `irq` sets on a loss declaration only if `int_mask` is 0, stays set after the loss clears, and is cleared by a one-cycle `int_clr` pulse.
- R8: `tx_sample_en` pulses once per transmit-clock rising edge when `cfg_tclk_fall` is 0, and once per falling edge when it is 1.
- R9: After reset, `tclk_lost` and `irq` are 0, and `drv_oe` is 0 until a master-clock transition has been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_in | input | 1 | Raw master clock |
| tclk_in | input | 1 | Raw transmit clock |
| mclk_present | input | 1 | 1 when the master clock is running |
| cfg_tclk_fall | input | 1 | 1 = sample transmit data on the falling edge |
| cfg_patt_mclk | input | 1 | 1 = master clock paces all ones, all zeros and PRBS |
| tx_all_ones | input | 1 | Send all ones |
| tx_all_zeros | input | 1 | Send all zeros |
| tx_prbs | input | 1 | Send PRBS |
| auto_all_ones | input | 1 | Automatic all ones (master clock forced) |
| ais_en | input | 1 | AIS enabled (master clock forced) |
| remote_lb | input | 1 | Remote loopback active |
| int_mask | input | 1 | 1 = suppress the loss interrupt |
| int_clr | input | 1 | Write-one-to-clear strobe for `irq` |
| tclk_lost | output | 1 | Live transmit clock loss status |
| irq | output | 1 | Sticky loss interrupt |
| patt_clk_en | output | 1 | One-cycle strobe of the selected pattern clock |
| tx_sample_en | output | 1 | One-cycle transmit data sample strobe |
| drv_oe | output | 1 | Line driver enable (0 = high impedance) |

## Verification
The hardest state to reach is a declared loss combined with each driver-keeping exception. The bench stops the transmit clock for well over the limit while the master clock runs. It then steps remote loopback, PRBS with each reference setting, and automatic all ones with the selection bit cleared, checking the driver enable after each step. The reference selection is checked with the two raw clocks running at slightly different periods. Each strobe is compared against the level of the clock it should follow.

// File: rtl/tlm_pkg.sv
// Shared types for the transmit clock loss monitor.
// Assumes nothing beyond plain SystemVerilog packages.
package tlm_pkg;
    // Active transmit pattern request bits.
    typedef struct packed {
        logic all_ones;
        logic all_zeros;
        logic prbs;
        logic auto_ones;
        logic ais;
    } tx_mode_t;
endpackage

// File: rtl/tlm_edge_sync.sv
// Synchronizes a slow raw clock into the system domain and reports its edges.
// Assumes the raw clock's half period spans several system clock cycles.
module tlm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic rise,
    output logic fall
);
    localparam int W = STAGES + 1;

    logic [W-1:0] shreg;

    // Shift the raw level through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[W-2:0], raw_in};
    end

    assign rise = shreg[W-2] & ~shreg[W-1];
    assign fall = ~shreg[W-2] & shreg[W-1];
endmodule

// File: rtl/tlm_idle_cnt.sv
// Counts master-clock edges since the last transmit clock edge and flags loss.
// Assumes edge strobes are single system cycles wide.
module tlm_idle_cnt #(
    parameter int LOSS_LIMIT = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_tick,
    input  logic tclk_act,
    output logic lost
);
    localparam int CW = $clog2(LOSS_LIMIT + 2);
    localparam logic [CW-1:0] SAT = CW'(LOSS_LIMIT + 1);

    logic [CW-1:0] cnt;

    // Clear on transmit activity, else count master edges up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (tclk_act)              cnt <= '0;
        else if (mclk_tick && cnt != SAT) cnt <= cnt + 1'b1;
    end

    assign lost = (cnt == SAT);
endmodule

// File: rtl/tlm_tx_ctrl.sv
// Chooses the pattern clock, gates the line driver and holds the loss interrupt.
// Assumes mode bits are quasi-static configuration.
module tlm_tx_ctrl
    import tlm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  tx_mode_t mode,
    input  logic     cfg_patt_mclk,
    input  logic     remote_lb,
    input  logic     mclk_present,
    input  logic     mclk_act,
    input  logic     mclk_rise,
    input  logic     tclk_rise,
    input  logic     lost,
    input  logic     int_mask,
    input  logic     int_clr,
    output logic     irq,
    output logic     patt_clk_en,
    output logic     drv_oe
);
    logic lost_d;
    logic mclk_seen;
    logic forced_m;
    logic sel_m;
    logic patt_on;
    logic irq_set;

    assign forced_m = mode.auto_ones | mode.ais;
    assign sel_m    = forced_m | cfg_patt_mclk;
    assign patt_on  = mode.all_ones | mode.all_zeros | mode.prbs | forced_m;
    assign irq_set  = lost & ~lost_d & ~int_mask;

    // Remember the previous loss level for declaration detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lost_d <= 1'b0;
        else        lost_d <= lost;
    end

    // Track whether the master clock has been seen running since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)             mclk_seen <= 1'b0;
        else if (!mclk_present) mclk_seen <= 1'b0;
        else if (mclk_act)      mclk_seen <= 1'b1;
    end

    // Sticky interrupt: set on a new unmasked loss, cleared by strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (irq_set) irq <= 1'b1;
        else if (int_clr) irq <= 1'b0;
    end

    // Pattern strobe from the chosen reference.
    always_comb begin
        patt_clk_en = sel_m ? mclk_rise : tclk_rise;
    end

    // Driver enable: master clock required, loss tolerated only by exceptions.
    always_comb begin
        drv_oe = mclk_present & mclk_seen &
                 (~lost | remote_lb | (patt_on & sel_m));
    end
endmodule

// File: rtl/tclk_loss_mon.sv
// Top of the transmit clock loss monitor.
// Assumes clk is much faster than both raw clocks.
module tclk_loss_mon
    import tlm_pkg::*;
#(
    parameter int LOSS_LIMIT = 70,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_in,
    input  logic tclk_in,
    input  logic mclk_present,
    input  logic cfg_tclk_fall,
    input  logic cfg_patt_mclk,
    input  logic tx_all_ones,
    input  logic tx_all_zeros,
    input  logic tx_prbs,
    input  logic auto_all_ones,
    input  logic ais_en,
    input  logic remote_lb,
    input  logic int_mask,
    input  logic int_clr,
    output logic tclk_lost,
    output logic irq,
    output logic patt_clk_en,
    output logic tx_sample_en,
    output logic drv_oe
);
    logic     m_rise, m_fall, t_rise, t_fall;
    tx_mode_t mode;

    assign mode = '{all_ones: tx_all_ones, all_zeros: tx_all_zeros,
                    prbs: tx_prbs, auto_ones: auto_all_ones, ais: ais_en};

    tlm_edge_sync #(.STAGES(SYNC_STAGES)) u_msync (
        .clk(clk), .rst_n(rst_n), .raw_in(mclk_in), .rise(m_rise), .fall(m_fall)
    );

    tlm_edge_sync #(.STAGES(SYNC_STAGES)) u_tsync (
        .clk(clk), .rst_n(rst_n), .raw_in(tclk_in), .rise(t_rise), .fall(t_fall)
    );

    tlm_idle_cnt #(.LOSS_LIMIT(LOSS_LIMIT)) u_idle (
        .clk(clk), .rst_n(rst_n), .mclk_tick(m_rise),
        .tclk_act(t_rise | t_fall), .lost(tclk_lost)
    );

    tlm_tx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cfg_patt_mclk(cfg_patt_mclk),
        .remote_lb(remote_lb), .mclk_present(mclk_present),
        .mclk_act(m_rise | m_fall), .mclk_rise(m_rise), .tclk_rise(t_rise),
        .lost(tclk_lost), .int_mask(int_mask), .int_clr(int_clr),
        .irq(irq), .patt_clk_en(patt_clk_en), .drv_oe(drv_oe)
    );

    assign tx_sample_en = cfg_tclk_fall ? t_fall : t_rise;
endmodule

// File: rtl/tclk_loss_mon_chk.sv
// Property checker for the transmit clock loss monitor, bound to the top.
module tclk_loss_mon_chk (
    input logic clk,
    input logic rst_n,
    input logic mclk_present,
    input logic cfg_patt_mclk,
    input logic tx_all_ones,
    input logic tx_all_zeros,
    input logic tx_prbs,
    input logic auto_all_ones,
    input logic ais_en,
    input logic remote_lb,
    input logic int_mask,
    input logic int_clr,
    input logic tclk_lost,
    input logic irq,
    input logic drv_oe
);
    logic keep_m;
    assign keep_m = auto_all_ones | ais_en |
                    ((tx_all_ones | tx_all_zeros | tx_prbs) & cfg_patt_mclk);

    // R4
    mclk_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mclk_present |-> !drv_oe);

    // R3
    loss_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tclk_lost && !remote_lb && !keep_m) |-> !drv_oe);

    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(tclk_lost) && !$past(int_mask)));

    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clr && !tclk_lost) |=> !irq);
endmodule

bind tclk_loss_mon tclk_loss_mon_chk u_chk (.*);

// File: tb/tclk_loss_mon_tb.sv
module tclk_loss_mon_tb;
    logic clk = 0;
    logic rst_n = 0;
    logic mclk_in = 0, tclk_in = 0;
    logic mclk_present = 1, cfg_tclk_fall = 0, cfg_patt_mclk = 0;
    logic tx_all_ones = 0, tx_all_zeros = 0, tx_prbs = 0;
    logic auto_all_ones = 0, ais_en = 0, remote_lb = 0;
    logic int_mask = 0, int_clr = 0;
    logic tclk_lost, irq, patt_clk_en, tx_sample_en, drv_oe;
    logic m_run = 0, t_run = 0;
    int   n_tests = 0, n_fail = 0;

    localparam int MP = 24; // master period in system cycles
    localparam int TH = 13; // transmit half period

    always #10 clk = ~clk;

    tclk_loss_mon u_dut (.*);

    // Raw master clock generator.
    initial forever begin
        repeat (MP/2) @(posedge clk);
        if (m_run) mclk_in <= ~mclk_in;
    end

    // Raw transmit clock generator; holds its level when stopped.
    initial forever begin
        repeat (TH) @(posedge clk);
        if (t_run) tclk_in <= ~tclk_in;
    end

    task automatic chk(input logic act, input logic exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        wait_cyc(5);
        rst_n = 1;
        wait_cyc(30);
        chk(tclk_lost, 0, "R9 lost after reset");
        chk(irq, 0, "R9 irq after reset");
        chk(drv_oe, 0, "R9 driver hiz before mclk");
        m_run = 1; t_run = 1;
        wait_cyc(100);
        chk(drv_oe, 1, "R9 driver on with mclk");
        chk(tclk_lost, 0, "R1 running clock not lost");
    endtask

    task automatic t_loss;
        t_run = 0;
        wait_cyc(60 * MP);
        chk(tclk_lost, 0, "R1 not lost at 60");
        wait_cyc(20 * MP);
        chk(tclk_lost, 1, "R1 lost after limit");
        chk(irq, 1, "R7 irq set unmasked");
        chk(drv_oe, 0, "R3 hiz on loss");
    endtask

    task automatic t_exceptions;
        remote_lb = 1; wait_cyc(2);
        chk(drv_oe, 1, "R3 loopback keeps driver");
        remote_lb = 0; tx_prbs = 1; cfg_patt_mclk = 1; wait_cyc(2);
        chk(drv_oe, 1, "R3 prbs on mclk keeps driver");
        cfg_patt_mclk = 0; wait_cyc(2);
        chk(drv_oe, 0, "R3 prbs on tclk hiz");
        tx_prbs = 0; auto_all_ones = 1; wait_cyc(2);
        chk(drv_oe, 1, "R6 auto ones ignores select");
        auto_all_ones = 0; ais_en = 1; wait_cyc(2);
        chk(drv_oe, 1, "R6 ais ignores select");
        remote_lb = 1; mclk_present = 0; wait_cyc(2);
        chk(drv_oe, 0, "R4 mclk absent forces hiz");
        mclk_present = 1; ais_en = 0; remote_lb = 0; wait_cyc(MP * 2);
    endtask

    task automatic t_recover;
        t_run = 1;
        wait_cyc(4 * TH);
        chk(tclk_lost, 0, "R2 loss clears on activity");
        chk(irq, 1, "R7 irq sticky");
        chk(drv_oe, 1, "R3 driver back");
        int_clr = 1; wait_cyc(1); int_clr = 0; wait_cyc(1);
        chk(irq, 0, "R7 irq cleared by strobe");
    endtask

    task automatic t_mask;
        int_mask = 1; t_run = 0;
        wait_cyc(80 * MP);
        chk(tclk_lost, 1, "R1 lost while masked");
        chk(irq, 0, "R7 masked no irq");
        t_run = 1; wait_cyc(4 * TH);
        int_mask = 0; wait_cyc(2);
        chk(irq, 0, "R7 irq stays clear");
    endtask

    // Count strobes and verify the followed raw clock level at each one.
    task automatic strobe_scan(input bit use_patt, input bit follow_m,
                               input logic lvl, input string req);
        int pulses = 0, bad = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (use_patt ? patt_clk_en : tx_sample_en) begin
                pulses++;
                if ((follow_m ? mclk_in : tclk_in) !== lvl) bad++;
            end
        end
        chk(pulses > 10, 1, {req, " pulses"});
        chk(bad == 0, 1, {req, " edge"});
    endtask

    task automatic t_select;
        tx_all_ones = 1; cfg_patt_mclk = 1;
        strobe_scan(1, 1, 1, "R5 mclk reference");
        cfg_patt_mclk = 0;
        strobe_scan(1, 0, 1, "R5 tclk reference");
        tx_all_ones = 0; tx_all_zeros = 1; ais_en = 1;
        strobe_scan(1, 1, 1, "R6 ais forces mclk");
        ais_en = 0; tx_all_zeros = 0;
        cfg_tclk_fall = 0;
        strobe_scan(0, 0, 1, "R8 rising sample");
        cfg_tclk_fall = 1;
        strobe_scan(0, 0, 0, "R8 falling sample");
    endtask

    initial begin
        t_reset;
        t_loss;
        t_exceptions;
        t_recover;
        t_mask;
        t_select;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule